// File: doc/BRIEF.md
# Privilege-Gated State-Enable Register, Upper Half

This block holds the upper 32 bits of a 64-bit hypervisor-level state-enable register on a 32-bit hart. Each implemented field grants a guest access to one group of supervisor-visible state. A guest can reach that state only when the hypervisor has set the field and the machine level allows it. Software reaches the register through a simple CSR port at address 0x61c. The port has an address, a write enable, write data and combinational read data.

A second input carries the upper 32 bits of the machine-level enable register. This input filters the register in two places:
- **On a write:** a field is stored as written only when its machine-level bit is 1. Otherwise the field is stored as 0.
- **On a read and on export:** the stored value is ANDed with the current machine-level bits. Clearing a machine bit therefore hides a field at once, even if the field was set earlier.

The block exports the filtered vector so that access-check logic elsewhere can use it.

Top module: `hyp_gate_hi`

## Requirements
- R1: After reset, every stored field is 0. The read data and the effective enable output are then 0.
- R2: A cycle with write enable high and address 0x61c stores, at that clock edge, each implemented field whose machine bit is 1. The field takes its write-data bit. The implemented fields are bits 31, 30, 28, 27, 26, 25 and 22 (mask 0xDE400000).
- R3: A field whose machine bit is 0 at the write edge is stored as 0. Setting the machine bit later does not reveal the written value.
- R4: Bits outside the mask 0xDE400000 always read as 0 and always export as 0. Writes to them are ignored.
- R5: A write cycle to any address other than 0x61c leaves the stored value unchanged.
- R6: The read data is 0 whenever the address is not 0x61c.
- R7: The read data and the effective output equal the stored value ANDed with the current machine bits and the field mask. A field set earlier reappears if its machine bit is set again.
- R8: The control-transfer-record field (bit 22) reads as 0 and exports as 0 whenever machine bit 22 is 0.
- R9: Effective-output bit 26 gives guest access to the interrupt file. It is 0 unless both stored bit 26 and machine bit 26 are 1.
- R10: With write enable low, nothing is stored, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrAddr | input | 12 | CSR address |
| csrWe | input | 1 | CSR write enable |
| csrWdata | input | 32 | CSR write data |
| machEnHi | input | 32 | Upper half of the machine-level enable register |
| csrRdata | output | 32 | Read data, combinational |
| effEnable | output | 32 | Filtered enable vector for access checks |

## Verification
The assertions assume that the address, write enable, write data and machine bits are stable and known around each rising edge, and that reset is applied synchronously from time zero. The bench changes every input only on the falling edge, so this assumption holds. The stimulus also draws the machine bits independently of the write data, which exercises both the permitted and the denied write paths. Directed cases cover:
- a machine bit cleared and then set again after a write;
- writes to neighbouring addresses;
- writes to the unimplemented bits.

// File: rtl/hyp_gate_pkg.sv
package hyp_gate_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] REG_ADDR   = 12'h61c;
  localparam logic [DATA_W-1:0] FIELD_MASK = 32'hDE40_0000;
  localparam int CTR_BIT   = 22;
  localparam int GUEST_INT_BIT = 26;

  typedef struct packed {
    logic wrStrobe;
    logic rdSel;
  } ctlStrobes_t;
endpackage

// File: rtl/hyp_gate_ctrl.sv
module hyp_gate_ctrl
  import hyp_gate_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] MY_ADDR = REG_ADDR
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] csrAddr,
  input  logic          csrWe,
  output ctlStrobes_t   strb
);
  logic addrHit;

  always_comb begin
    addrHit      = (csrAddr == MY_ADDR);
    strb.rdSel   = addrHit;
    strb.wrStrobe = addrHit && csrWe;
  end

  // R10
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csrWe |-> !strb.wrStrobe);
  // R5
  no_write_other_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr != MY_ADDR) |-> !strb.wrStrobe && !strb.rdSel);
endmodule

// File: rtl/hyp_gate_dp.sv
module hyp_gate_dp
  import hyp_gate_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter logic [DW-1:0] MASK = FIELD_MASK
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   strb,
  input  logic [DW-1:0] csrWdata,
  input  logic [DW-1:0] machEnHi,
  output logic [DW-1:0] csrRdata,
  output logic [DW-1:0] effEnable
);
  logic [DW-1:0] stored;
  logic [DW-1:0] gatedWrite;
  logic [DW-1:0] visible;

  always_comb gatedWrite = csrWdata & machEnHi & MASK;

  always_ff @(posedge clk) begin
    if (!rstN)              stored <= '0;
    else if (strb.wrStrobe) stored <= gatedWrite;
  end

  always_comb begin
    visible   = stored & machEnHi & MASK;
    effEnable = visible;
    csrRdata  = strb.rdSel ? visible : '0;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) $past(!rstN) |-> stored == '0);
  // R2
  write_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStrobe |=> stored == ($past(csrWdata & machEnHi) & MASK));
  // R3
  write_deny_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStrobe |=> (stored & ~$past(machEnHi)) == '0);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrStrobe |=> $stable(stored));
  // R4
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((csrRdata | effEnable) & ~MASK) == '0);
  // R6
  rd_unsel_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdSel |-> csrRdata == '0);
  // R7
  eff_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (effEnable & ~machEnHi) == '0);
  // R8
  ctr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !machEnHi[CTR_BIT] |-> !effEnable[CTR_BIT] && !csrRdata[CTR_BIT]);
endmodule

// File: rtl/hyp_gate_hi.sv
module hyp_gate_hi
  import hyp_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrWe,
  input  logic [DATA_W-1:0] csrWdata,
  input  logic [DATA_W-1:0] machEnHi,
  output logic [DATA_W-1:0] csrRdata,
  output logic [DATA_W-1:0] effEnable
);
  ctlStrobes_t strb;

  hyp_gate_ctrl #(.AW(ADDR_W), .MY_ADDR(REG_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrWe(csrWe), .strb(strb)
  );

  hyp_gate_dp #(.DW(DATA_W), .MASK(FIELD_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .csrWdata(csrWdata),
    .machEnHi(machEnHi), .csrRdata(csrRdata), .effEnable(effEnable)
  );

  // R9
  guest_int_chk: assert property (@(posedge clk) disable iff (!rstN)
    effEnable[GUEST_INT_BIT] |-> machEnHi[GUEST_INT_BIT]);
endmodule

// File: tb/hyp_gate_hi_bench.sv
module hyp_gate_hi_bench;
  localparam logic [31:0] MASK = 32'hDE40_0000;
  localparam logic [11:0] ADDR = 12'h61c;

  logic clk = 0, rstN = 0, csrWe = 0;
  logic [11:0] csrAddr = 0;
  logic [31:0] csrWdata = 0, machEnHi = 0, csrRdata, effEnable;
  logic [31:0] model = 0;
  int tests = 0, fails = 0;
  int unsigned seed = 32'd1234;

  always #5 clk = ~clk;

  hyp_gate_hi u_hyp_gate_hi (.clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrWe(csrWe),
    .csrWdata(csrWdata), .machEnHi(machEnHi), .csrRdata(csrRdata), .effEnable(effEnable));

  function automatic logic [31:0] expEff(logic [31:0] st, logic [31:0] m);
    return st & m & MASK;
  endfunction
  function automatic logic [31:0] expRd(logic [31:0] st, logic [31:0] m, logic [11:0] a);
    return (a == ADDR) ? (st & m & MASK) : 32'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkOut(string req);
    #1;
    check(req, csrRdata, expRd(model, machEnHi, csrAddr));
    check(req, effEnable, expEff(model, machEnHi));
  endtask

  // drive at negedge, capture at posedge, return at negedge
  task automatic cyc(logic [11:0] a, logic we, logic [31:0] d, logic [31:0] m);
    csrAddr = a; csrWe = we; csrWdata = d; machEnHi = m;
    @(posedge clk);
    if (we && a == ADDR) model = d & m & MASK;
    @(negedge clk);
    csrWe = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    machEnHi = '1; csrAddr = ADDR;
    repeat (3) @(negedge clk);
    checkOut("R1 reset");
    rstN = 1;
    @(negedge clk);
    checkOut("R1 after reset");

    cyc(ADDR, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    checkOut("R2 full write");
    check("R4 unimpl bits", csrRdata, MASK);

    cyc(ADDR, 1, 32'hFFFF_FFFF, 32'h0400_0000);
    checkOut("R3 partial machine");
    machEnHi = '1; checkOut("R3 not revealed");
    check("R9 guest int only", effEnable, 32'h0400_0000);

    cyc(ADDR, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    machEnHi = 32'hFFBF_FFFF; checkOut("R8 ctr hidden");
    check("R8 bit22", {31'h0, effEnable[22]}, 32'h0);
    machEnHi = 32'h0; checkOut("R7 all hidden");
    machEnHi = '1; checkOut("R7 reappear");
    check("R7 reappear value", effEnable, MASK);

    cyc(12'h61d, 1, 32'h0, 32'hFFFF_FFFF);
    csrAddr = ADDR; checkOut("R5 other addr");
    check("R5 kept", csrRdata, MASK);
    csrAddr = 12'h61b; checkOut("R6 read other addr");
    check("R6 zero", csrRdata, 32'h0);

    cyc(ADDR, 0, 32'h0, 32'hFFFF_FFFF);
    checkOut("R10 we low");
    check("R10 kept", csrRdata, MASK);

    cyc(ADDR, 1, 32'h0400_0000, 32'hFFFF_FFFF);
    machEnHi = 32'hFBFF_FFFF; checkOut("R9 guest blocked by machine");
    check("R9 bit26", {31'h0, effEnable[26]}, 32'h0);
    cyc(ADDR, 1, 32'h0, 32'hFFFF_FFFF);
    checkOut("R9 stored clear");

    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      a = ($urandom % 4 == 0) ? 12'($urandom) : ADDR;
      cyc(a, 1'($urandom), $urandom, $urandom);
      machEnHi = $urandom;
      checkOut("R7 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule